// File: doc/BRIEF.md
# Fast EPROM Programming Sequencer

This controller drives a byte-wide UV-erasable PROM through a fast programming flow. It starts at location zero and raises the elevated core supply flag. Once that supply has settled it raises the programming voltage flag. It then takes one data byte per location from a ready/valid source. For each byte it drives the address and the data bus for a setup interval, then fires a timed programming pulse on the active-low chip enable. It keeps the data on the bus for a hold interval after the pulse. It then releases the bus and reads the location back with output enable low and chip enable high.

A byte that reads back wrong ends the run. The supplies are brought down in reverse order and the run reports done together with fail. When every location has passed, the supplies are lowered and the whole device is read again at nominal supply with chip enable and output enable both low. The sum of the bytes read back is compared with the sum of the bytes accepted from the source, and only a match reports a pass. Every interval is a cycle count computed from a clock-frequency parameter, so the same RTL serves any clock.

States are IDLE, RAISE_VCC, RAISE_VPP, FETCH, SETUP, PULSE, HOLD, VERIFY, LOWER_VPP, LOWER_VCC, SWEEP and END. The transitions are as follows:
- IDLE goes to RAISE_VCC on start.
- RAISE_VCC goes to RAISE_VPP, and RAISE_VPP goes to FETCH, each when its settle time expires.
- FETCH goes to SETUP when a byte is accepted.
- SETUP goes to PULSE, PULSE goes to HOLD, and HOLD goes to VERIFY, each on timer expiry.
- VERIFY goes to FETCH when the byte matches and it is not the last location. It goes to LOWER_VPP when the byte mismatches, which is the abort path, or when the last location has passed.
- LOWER_VPP goes to LOWER_VCC on timer expiry.
- LOWER_VCC goes to SWEEP after a clean programming pass, or to END after an abort.
- SWEEP steps through all addresses and then goes to END.
- END goes to IDLE.

Top module: `epg_sequencer`

## Requirements
- R1: While reset is low and while idle after reset, chip enable and output enable are high (1), the bus drive enable, both supply flags, src_ready, busy, done and fail are all 0.
- R2: After start, the core supply flag rises first and the programming voltage flag rises exactly SETUP_CYC cycles later. At the end of a run the programming voltage flag falls first and the core flag falls exactly SETUP_CYC cycles later. The programming voltage flag is never high while the core flag is low.
- R3: Bytes are accepted only on a cycle where src_valid and src_ready are both 1, at most one per location. Locations are taken in ascending order from address 0 to address 2^ADDR_W-1.
- R4: Before each pulse, address and data are driven with output enable high for exactly SETUP_CYC cycles, with the programming voltage already on.
- R5: The programming pulse holds chip enable low for exactly PULSE_CYC cycles, with output enable high and address and data stable.
- R6: After chip enable rises, the data bus stays driven for exactly HOLD_CYC cycles.
- R7: Each per-byte verify releases the bus and holds output enable low with chip enable high for exactly READ_CYC cycles. The read byte is compared in the last of those cycles, so a location whose stored bits cannot match the data (only 1 to 0 changes are possible) fails the run.
- R8: A verify mismatch aborts the run: no further byte is accepted, the supplies are lowered per R2, and done=1 with fail=1 is reported.
- R9: After the last location passes, the supplies are lowered. Every location is then read with chip enable and output enable low for READ_CYC cycles each. The run reports done=1 and fail=0 only if the sum of bytes read equals the sum of bytes accepted; otherwise it reports done=1 and fail=1.
- R10: busy is high from the cycle after start is taken until the run ends. A start seen while busy is ignored. done and fail hold their values until the next accepted start, which clears them.
- R11: SETUP_CYC = CLK_MHZ*SETUP_US, PULSE_CYC = CLK_MHZ*PULSE_US, HOLD_CYC = CLK_MHZ*HOLD_US and READ_CYC = ceil(CLK_MHZ*READ_NS/1000)+1, each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run (taken in IDLE) |
| src_data | input | DATA_W | Byte offered by the source |
| src_valid | input | 1 | Source has a byte |
| src_ready | output | 1 | Sequencer takes a byte this cycle |
| prom_addr | output | ADDR_W | Device address |
| prom_dq_out | output | DATA_W | Data driven onto the device bus |
| prom_dq_drive | output | 1 | Sequencer drives the data bus |
| prom_dq_in | input | DATA_W | Data read from the device bus |
| prom_ce_n | output | 1 | Chip enable, active low (programming pulse) |
| prom_oe_n | output | 1 | Output enable, active low |
| core_sup_hi | output | 1 | Select elevated core supply |
| prog_sup_on | output | 1 | Select programming voltage |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| fail | output | 1 | Finished run failed (held) |

## Verification
A stuck or mis-sequenced state shows at the pins within one interval. A pulse, setup, hold or read window of the wrong length is measured directly on chip enable, output enable and the drive enable at the next edge of that window. A wrong address step or a lost byte shows up as a wrong device image or a wrong count of accepted bytes by the end of the run. Faults injected into the device model cover both failure paths. A location that cannot take its data must abort at that byte, with no further bytes accepted. A location that reads differently at nominal supply must fail only after the full final sweep.

// File: rtl/epg_pkg.sv
`timescale 1ns/1ps
package epg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAISE_VCC,
        ST_RAISE_VPP,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY,
        ST_LOWER_VPP,
        ST_LOWER_VCC,
        ST_SWEEP,
        ST_END
    } epg_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic dq_drive;
        logic core_hi;
        logic prog_on;
        logic take;
    } epg_pins_t;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/epg_timer.sv
`timescale 1ns/1ps
module epg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // A loaded count must run down without skipping: nonzero never jumps to a
    // value other than one less unless reloaded.
    assert_timer_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/epg_addr_walker.sv
`timescale 1ns/1ps
module epg_addr_walker #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == {ADDR_W{1'b1}});

    // The walk never wraps past the top location.
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && at_last && !clear));

    // Addresses only move upward by one.
    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/epg_sum.sv
`timescale 1ns/1ps
module epg_sum #(
    parameter int DW = 8,
    parameter int SW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          add,
    input  logic [DW-1:0] value,
    output logic [SW-1:0] sum
);
    logic [SW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + SW'(value);
        end
    end

    assign sum = acc_q;

endmodule

// File: rtl/epg_sequencer.sv
`timescale 1ns/1ps
module epg_sequencer
    import epg_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_MHZ  = 200,
    parameter int SETUP_US = 2,
    parameter int PULSE_US = 1000,
    parameter int HOLD_US  = 2,
    parameter int READ_NS  = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [ADDR_W-1:0] prom_addr,
    output logic [DATA_W-1:0] prom_dq_out,
    output logic              prom_dq_drive,
    input  logic [DATA_W-1:0] prom_dq_in,
    output logic              prom_ce_n,
    output logic              prom_oe_n,
    output logic              core_sup_hi,
    output logic              prog_sup_on,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int SETUP_CYC = at_least_one(CLK_MHZ * SETUP_US);
    localparam int PULSE_CYC = at_least_one(CLK_MHZ * PULSE_US);
    localparam int HOLD_CYC  = at_least_one(CLK_MHZ * HOLD_US);
    localparam int READ_CYC  = at_least_one((CLK_MHZ * READ_NS + 999) / 1000 + 1);
    localparam int MAX_A     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B     = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W     = $clog2(MAX_CYC + 1);
    localparam int SUM_W     = DATA_W + ADDR_W;

    localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_PULSE = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_HOLD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] LD_READ  = TMR_W'(READ_CYC - 1);

    epg_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              abort_q, done_q, fail_q;

    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              addr_clr, addr_step, addr_last;
    logic [ADDR_W-1:0] addr_q;
    logic              sums_clr, psum_add, rsum_add;
    logic [SUM_W-1:0]  psum, rsum;
    logic              latch, abort_set, start_acc, verify_ok;
    epg_pins_t         pins;

    epg_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    epg_addr_walker #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (addr_clr),
        .step    (addr_step),
        .addr    (addr_q),
        .at_last (addr_last)
    );

    epg_sum #(.DW(DATA_W), .SW(SUM_W)) u_prog_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sums_clr),
        .add   (psum_add),
        .value (src_data),
        .sum   (psum)
    );

    epg_sum #(.DW(DATA_W), .SW(SUM_W)) u_read_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sums_clr),
        .add   (rsum_add),
        .value (prom_dq_in),
        .sum   (rsum)
    );

    assign verify_ok = (prom_dq_in == data_q);

    // Next state, timer loads and datapath strobes.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = LD_SETUP;
        addr_clr  = 1'b0;
        addr_step = 1'b0;
        sums_clr  = 1'b0;
        psum_add  = 1'b0;
        rsum_add  = 1'b0;
        latch     = 1'b0;
        abort_set = 1'b0;
        start_acc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    start_acc = 1'b1;
                    addr_clr  = 1'b1;
                    sums_clr  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                    state_d   = ST_RAISE_VCC;
                end
            end
            ST_RAISE_VCC: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                    state_d  = ST_RAISE_VPP;
                end
            end
            ST_RAISE_VPP: begin
                if (tmr_exp) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (src_valid) begin
                    latch    = 1'b1;
                    psum_add = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                    state_d  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                    state_d  = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                    state_d  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_READ;
                    state_d  = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (tmr_exp) begin
                    if (!verify_ok || addr_last) begin
                        abort_set = !verify_ok;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_SETUP;
                        state_d   = ST_LOWER_VPP;
                    end else begin
                        addr_step = 1'b1;
                        state_d   = ST_FETCH;
                    end
                end
            end
            ST_LOWER_VPP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                    state_d  = ST_LOWER_VCC;
                end
            end
            ST_LOWER_VCC: begin
                if (tmr_exp) begin
                    if (abort_q) begin
                        state_d = ST_END;
                    end else begin
                        addr_clr = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_READ;
                        state_d  = ST_SWEEP;
                    end
                end
            end
            ST_SWEEP: begin
                if (tmr_exp) begin
                    rsum_add = 1'b1;
                    if (addr_last) begin
                        state_d = ST_END;
                    end else begin
                        addr_step = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_READ;
                    end
                end
            end
            ST_END: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with the few registers that travel with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            abort_q <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (latch) data_q <= src_data;
            if (start_acc) begin
                abort_q <= 1'b0;
                done_q  <= 1'b0;
                fail_q  <= 1'b0;
            end
            if (abort_set) abort_q <= 1'b1;
            if (state_q == ST_END) begin
                done_q <= 1'b1;
                fail_q <= abort_q || (psum != rsum);
            end
        end
    end

    // Pin levels per state.
    always_comb begin
        pins = '{ce_n: 1'b1, oe_n: 1'b1, dq_drive: 1'b0,
                 core_hi: 1'b0, prog_on: 1'b0, take: 1'b0};
        unique case (state_q)
            ST_IDLE, ST_END, ST_LOWER_VCC: ;
            ST_RAISE_VCC: pins.core_hi = 1'b1;
            ST_RAISE_VPP: begin
                pins.core_hi = 1'b1;
                pins.prog_on = 1'b1;
            end
            ST_FETCH: begin
                pins.core_hi = 1'b1;
                pins.prog_on = 1'b1;
                pins.take    = 1'b1;
            end
            ST_SETUP, ST_HOLD: begin
                pins.core_hi  = 1'b1;
                pins.prog_on  = 1'b1;
                pins.dq_drive = 1'b1;
            end
            ST_PULSE: begin
                pins.core_hi  = 1'b1;
                pins.prog_on  = 1'b1;
                pins.dq_drive = 1'b1;
                pins.ce_n     = 1'b0;
            end
            ST_VERIFY: begin
                pins.core_hi = 1'b1;
                pins.prog_on = 1'b1;
                pins.oe_n    = 1'b0;
            end
            ST_LOWER_VPP: pins.core_hi = 1'b1;
            ST_SWEEP: begin
                pins.ce_n = 1'b0;
                pins.oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign src_ready     = pins.take;
    assign prom_addr     = addr_q;
    assign prom_dq_out   = data_q;
    assign prom_dq_drive = pins.dq_drive;
    assign prom_ce_n     = pins.ce_n;
    assign prom_oe_n     = pins.oe_n;
    assign core_sup_hi   = pins.core_hi;
    assign prog_sup_on   = pins.prog_on;
    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign fail          = fail_q;

    assert_vpp_needs_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_sup_on |-> core_sup_hi);

    assert_core_before_vpp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_sup_on) |-> $past(core_sup_hi));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(prom_dq_drive && !prom_oe_n));

    assert_data_before_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prom_ce_n) && prom_dq_drive) |-> ($past(prom_dq_drive) && prog_sup_on));

    assert_pulse_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prom_ce_n && prom_dq_drive) |-> (prom_oe_n && prog_sup_on));

    assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prom_ce_n && prom_dq_drive && $past(!prom_ce_n && prom_dq_drive))
            |-> ($stable(prom_addr) && $stable(prom_dq_out)));

    assert_hold_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prom_ce_n) && $past(prom_dq_drive)) |-> prom_dq_drive);

    assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    assert_take_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (busy && prog_sup_on));

endmodule

// File: tb/tb_epg_sequencer.sv
`timescale 1ns/1ps
module tb_epg_sequencer;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int NB       = 1 << ADDR_W;
    localparam int CLK_MHZ  = 2;
    localparam int SETUP_US = 2;
    localparam int PULSE_US = 10;
    localparam int HOLD_US  = 2;
    localparam int READ_NS  = 150;
    // R11: expected interval lengths
    localparam int SETUP_E  = CLK_MHZ * SETUP_US;
    localparam int PULSE_E  = CLK_MHZ * PULSE_US;
    localparam int HOLD_E   = CLK_MHZ * HOLD_US;
    localparam int READ_E   = (CLK_MHZ * READ_NS + 999) / 1000 + 1;
    localparam int LIMIT    = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_valid = 1'b0;
    logic              src_ready;
    logic [ADDR_W-1:0] prom_addr;
    logic [DATA_W-1:0] prom_dq_out;
    logic              prom_dq_drive;
    logic [DATA_W-1:0] prom_dq_in;
    logic              prom_ce_n, prom_oe_n, core_sup_hi, prog_sup_on;
    logic              busy, done, fail;

    always #2.5 clk = ~clk;

    epg_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ), .SETUP_US(SETUP_US),
        .PULSE_US(PULSE_US), .HOLD_US(HOLD_US), .READ_NS(READ_NS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
        .src_valid(src_valid), .src_ready(src_ready), .prom_addr(prom_addr),
        .prom_dq_out(prom_dq_out), .prom_dq_drive(prom_dq_drive),
        .prom_dq_in(prom_dq_in), .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n),
        .core_sup_hi(core_sup_hi), .prog_sup_on(prog_sup_on),
        .busy(busy), .done(done), .fail(fail)
    );

    // Device model state and fault knobs
    logic [DATA_W-1:0] mem  [NB];
    logic [DATA_W-1:0] gold [NB];
    int weak_a = -1;
    int disturb_a = -1;
    logic ce_prev = 1'b1;

    always_comb begin
        prom_dq_in = '0;
        if (!prom_oe_n) begin
            prom_dq_in = mem[prom_addr];
            if (!prog_sup_on && int'(prom_addr) == disturb_a) prom_dq_in = prom_dq_in ^ 8'h10;
        end
    end

    int checks = 0, errors = 0, cyc = 0;
    int fidx = 0, consumed = 0;
    bit fire = 0;
    int pulses, pw_min, pw_max, pw_run;
    int su_min, su_max, pre_cnt;
    int hd_min, hd_max, post_cnt;
    bit in_post;
    int vr_min, vr_max, vr_run, sweep_cyc;
    int rise_cnt, fall_cnt, vv_rise, vv_fall;
    bit went_up, order_bad;

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        pulses = 0; pw_min = 1 << 30; pw_max = 0; pw_run = 0;
        su_min = 1 << 30; su_max = 0; pre_cnt = 0;
        hd_min = 1 << 30; hd_max = 0; post_cnt = 0; in_post = 0;
        vr_min = 1 << 30; vr_max = 0; vr_run = 0; sweep_cyc = 0;
        rise_cnt = 0; fall_cnt = 0; vv_rise = -1; vv_fall = -1;
        went_up = 0; order_bad = 0; consumed = 0; fidx = 0; fire = 0;
    endtask

    // One bench step: model, monitors and source, all at the falling edge.
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
            summary_and_end();
        end
        if (ce_prev == 1'b0 && prom_ce_n && prog_sup_on && core_sup_hi && prom_dq_drive)
            mem[prom_addr] = mem[prom_addr] &
                (prom_dq_out | ((int'(prom_addr) == weak_a) ? 8'h01 : 8'h00));
        ce_prev = prom_ce_n;
        // pulse width
        if (!prom_ce_n && prom_dq_drive) pw_run++;
        else if (pw_run > 0) begin
            pulses++;
            if (pw_run < pw_min) pw_min = pw_run;
            if (pw_run > pw_max) pw_max = pw_run;
            pw_run = 0;
        end
        // setup and hold
        if (!prom_dq_drive) begin
            pre_cnt = 0;
            if (in_post) begin
                if (post_cnt < hd_min) hd_min = post_cnt;
                if (post_cnt > hd_max) hd_max = post_cnt;
                in_post = 0;
            end
        end else if (prom_ce_n) begin
            if (in_post) post_cnt++; else pre_cnt++;
        end else if (!in_post) begin
            if (pre_cnt < su_min) su_min = pre_cnt;
            if (pre_cnt > su_max) su_max = pre_cnt;
            in_post = 1; post_cnt = 0;
        end
        // verify windows and sweep reads
        if (!prom_oe_n && prom_ce_n) vr_run++;
        else if (vr_run > 0) begin
            if (vr_run < vr_min) vr_min = vr_run;
            if (vr_run > vr_max) vr_max = vr_run;
            vr_run = 0;
        end
        if (!prom_oe_n && !prom_ce_n) sweep_cyc++;
        // supply ordering
        if (prog_sup_on && !core_sup_hi) order_bad = 1;
        if (core_sup_hi && !prog_sup_on && !went_up) rise_cnt++;
        if (prog_sup_on && !went_up) begin vv_rise = rise_cnt; went_up = 1; end
        if (core_sup_hi && !prog_sup_on && went_up) fall_cnt++;
        if (!core_sup_hi && went_up && vv_fall < 0 && fall_cnt > 0) vv_fall = fall_cnt;
        // source
        if (fire) begin consumed++; fidx++; end
        if (fidx < NB) begin
            if (!src_valid) src_valid = ($urandom % 4) != 0;
            src_data = gold[fidx];
        end else begin
            src_valid = 1'b0;
            src_data = '0;
        end
        fire = src_valid && src_ready;
    endtask

    task automatic prepare(input int pre_zero_a);
        clear_stats();
        src_valid = 1'b0;
        for (int i = 0; i < NB; i++) mem[i] = (i == pre_zero_a) ? 8'h00 : 8'hFF;
    endtask

    // Launch a run and wait for done; optional stray start while busy.
    task automatic launch(input int stray_at);
        int n;
        tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        chk(done == 1'b0, "R10", "done cleared by start", int'(done), 0);
        n = 0;
        while (!done && n < 4000) begin
            start = (n == stray_at);
            tick();
            n++;
        end
        start = 1'b0;
        tick();
    endtask

    task automatic check_image(input string req);
        int bad = 0;
        for (int i = 0; i < NB; i++) if (mem[i] != gold[i]) bad++;
        chk(bad == 0, req, "device image mismatching bytes", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd5151));
        clear_stats();
        for (int i = 0; i < NB; i++) begin gold[i] = 8'hFF; mem[i] = 8'hFF; end
        tick(); tick();
        // R1: during reset
        chk(prom_ce_n && prom_oe_n && !prom_dq_drive && !core_sup_hi && !prog_sup_on,
            "R1", "pins inactive in reset", int'(prom_ce_n), 1);
        rst_n = 1'b1;
        tick(); tick();
        chk(!busy && !done && !fail && !src_ready, "R1", "status idle after reset",
            int'({busy, done, fail, src_ready}), 0);

        // Run A: clean random image
        for (int i = 0; i < NB; i++) gold[i] = 8'($urandom);
        prepare(-1);
        launch(-1);
        chk(done && !fail, "R9", "pass status", int'(fail), 0);
        check_image("R3");
        chk(consumed == NB, "R3", "bytes accepted", consumed, NB);
        chk(pulses == NB, "R5", "pulse count", pulses, NB);
        chk(pw_min == PULSE_E && pw_max == PULSE_E, "R5", "pulse width", pw_max, PULSE_E);
        chk(su_min == SETUP_E && su_max == SETUP_E, "R4", "setup length", su_max, SETUP_E);
        chk(hd_min == HOLD_E && hd_max == HOLD_E, "R6", "hold length", hd_max, HOLD_E);
        chk(vr_min == READ_E && vr_max == READ_E, "R7", "verify window", vr_max, READ_E);
        chk(sweep_cyc == NB * READ_E, "R9", "final sweep read cycles", sweep_cyc, NB * READ_E);
        chk(vv_rise == SETUP_E, "R2", "core to vpp rise delay", vv_rise, SETUP_E);
        chk(vv_fall == SETUP_E, "R2", "vpp to core fall delay", vv_fall, SETUP_E);
        chk(order_bad == 0, "R2", "vpp without core", int'(order_bad), 0);
        chk(READ_E == 2 && PULSE_E == 20, "R11", "derived intervals", READ_E, 2);
        repeat (20) tick();
        chk(done && !fail && !busy, "R10", "status held while idle", int'(done), 1);

        // Run B: bit 0 of location 5 cannot be programmed, stray start mid-run
        for (int i = 0; i < NB; i++) gold[i] = 8'($urandom);
        gold[5] = gold[5] & 8'hFE;
        weak_a = 5;
        prepare(-1);
        launch(40);
        chk(done && fail, "R8", "abort on weak byte", int'(fail), 1);
        chk(consumed == 6, "R8", "bytes accepted before abort", consumed, 6);
        chk(pulses == 6, "R8", "pulses before abort", pulses, 6);
        chk(sweep_cyc == 0, "R8", "no sweep after abort", sweep_cyc, 0);
        chk(vv_fall == SETUP_E && order_bad == 0, "R2", "abort supply order", vv_fall, SETUP_E);
        chk(mem[3] == gold[3], "R10", "stray start ignored, byte 3 kept", int'(mem[3]), int'(gold[3]));
        weak_a = -1;

        // Run C: location 2 already all zero, data has ones
        for (int i = 0; i < NB; i++) gold[i] = 8'($urandom);
        gold[2] = 8'h5A;
        prepare(2);
        launch(-1);
        chk(done && fail, "R7", "zero cell cannot take ones", int'(fail), 1);
        chk(consumed == 3, "R7", "bytes accepted up to bad cell", consumed, 3);

        // Run D: location 6 reads differently once vpp is off
        for (int i = 0; i < NB; i++) gold[i] = 8'($urandom);
        disturb_a = 6;
        prepare(-1);
        launch(-1);
        chk(done && fail, "R9", "sweep sum mismatch fails", int'(fail), 1);
        chk(pulses == NB && sweep_cyc == NB * READ_E, "R9", "full flow before sweep fail",
            pulses, NB);
        disturb_a = -1;

        // Run E: more random clean images with random source stalls
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NB; i++) gold[i] = 8'($urandom);
            if (r == 1) for (int i = 0; i < NB; i++) gold[i] = 8'hFF;
            if (r == 2) for (int i = 0; i < NB; i++) gold[i] = 8'h00;
            prepare(-1);
            launch(-1);
            chk(done && !fail, "R9", "random pass status", int'(fail), 0);
            check_image("R3");
            chk(pw_max == PULSE_E && su_min == SETUP_E, "R4", "intervals on rerun", pw_max, PULSE_E);
        end

        summary_and_end();
    end

endmodule